// File: doc/BRIEF.md
# Serial Register-Access Slave for an 8-bit Port Expander

This block is the two-wire serial slave front end of an 8-bit port expander. It runs entirely on the system clock. SCL and SDA are oversampled through a synchronizer, and start and stop conditions are found by comparing consecutive synchronized samples. The block decodes a 7-bit slave address. The upper part of the address is fixed and the lower three bits come from strap inputs.

After a write address, the first byte is a command byte. It is loaded into a register pointer that the surrounding expander logic decodes: 0x00 is the input port, 0x01 the output latch, 0x02 the polarity inversion mask and 0x03 the direction register. Each byte after the command byte is handed to the register bank through a one-cycle write strobe.

After a read address, the block fetches the byte at the current pointer through a read-access strobe and shifts it out. The pointer survives stop and repeated start conditions. A transfer that carries only a read address therefore keeps returning the register that was last selected.

The SDA pin is open-drain. The block never drives a high level. It only asserts an output enable that pulls the line low.

Top module: `pexp_i2c_slave`

## Requirements
- R1: While reset is high, and directly after it, the SDA pull-down enable is low, the register pointer is 0x00, and both strobes are low.
- R2: An address byte is received MSB first as 0,1,0,0, then the three strap bits (high bit first), then the R/W bit (0 = write, 1 = read). When the first seven bits match, the block pulls SDA low during the ninth SCL clock to acknowledge.
- R3: When the address does not match, SDA stays released for the acknowledge bit. Every later byte is ignored until the next start: there is no acknowledge, no write strobe and no change of the pointer.
- R4: The first byte after a matching write address is acknowledged and becomes the new value of the register pointer output.
- R5: Every further byte of a write transfer is acknowledged. It produces exactly one single-cycle write strobe, with that byte on the write-data output and the pointer unchanged.
- R6: After a matching read address, the block raises a one-cycle read-access strobe and shifts the read-data byte out MSB first. The pull-down enable changes only while SCL is low.
- R7: When the master acknowledges a read byte, the next byte is fetched with a new read-access strobe. When the master does not acknowledge, SDA is released and no further fetch happens in that transfer.
- R8: The register pointer keeps its value across stop conditions, repeated starts and read transfers. A later read-only transfer returns the register last selected by a command byte.
- R9: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point, including in the middle of a byte, returns the block to the address phase. Both conditions release SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | Pull-down enable for SDA; 1 drives the line low |
| strap_addr | input | 3 | Low three address bits from strap pins |
| reg_ptr | output | 8 | Register pointer loaded by the command byte |
| wr_stb | output | 1 | One-cycle strobe: write wr_data to register reg_ptr |
| wr_data | output | 8 | Data byte to be written |
| rd_data | input | 8 | Contents of register reg_ptr, supplied by the register bank |
| rd_stb | output | 1 | One-cycle strobe marking the fetch of rd_data |

## Verification
The hardest case to reach from the pins is a start condition that arrives part-way through an address byte, or directly after a command byte with no stop in between. Both must reset the bit position without touching the stored pointer. The stimulus bit-bangs the serial lines from a master model. It abandons an address after three bits and reissues a start. It also chains a command-byte write, through a repeated start, into a read transfer. Then it checks that the read data and later write strobes follow the surviving pointer. A scoreboard checks every strobe against the queue of accesses the master expects, so any extra fetch or write, including one after a refused address or a master NACK, is reported.

// File: rtl/pexp_i2c_pkg.sv
package pexp_i2c_pkg;

    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int FIX_W   = BYTE_W - 1 - STRAP_W;
    localparam int CNT_W   = $clog2(BYTE_W);

    // Fixed upper part of the 7-bit slave address
    localparam logic [FIX_W-1:0] ADDR_FIXED = 4'b0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } xfer_st_t;

    typedef enum logic [1:0] {
        PH_BITS,
        PH_ACKWAIT,
        PH_ACK
    } bit_ph_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic hit;
        logic rnw;
    } addr_dec_t;

    function automatic addr_dec_t decode_addr(input logic [BYTE_W-1:0] b,
                                              input logic [STRAP_W-1:0] strap);
        addr_dec_t d;
        d.hit = (b[BYTE_W-1 -: FIX_W] == ADDR_FIXED) && (b[STRAP_W:1] == strap);
        d.rnw = b[0];
        return d;
    endfunction

endpackage

// File: rtl/pexp_line_sync.sv
module pexp_line_sync
    import pexp_i2c_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    localparam int LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Idle bus is high on both lines
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[g]};
            end
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '1;
        end else begin
            lvl_q <= lvl;
        end
    end

    always_comb begin
        ev.scl      = lvl[IDX_SCL];
        ev.sda      = lvl[IDX_SDA];
        ev.scl_rise = lvl[IDX_SCL] & ~lvl_q[IDX_SCL];
        ev.scl_fall = ~lvl[IDX_SCL] & lvl_q[IDX_SCL];
        ev.start    = lvl[IDX_SCL] & lvl_q[IDX_SCL] & lvl_q[IDX_SDA] & ~lvl[IDX_SDA];
        ev.stop     = lvl[IDX_SCL] & lvl_q[IDX_SCL] & ~lvl_q[IDX_SDA] & lvl[IDX_SDA];
    end

endmodule

// File: rtl/pexp_ptr_reg.sv
module pexp_ptr_reg
    import pexp_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] val,
    output logic [BYTE_W-1:0] ptr
);

    // Only a command byte moves the pointer; bus conditions never clear it
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= val;
        end
    end

endmodule

// File: rtl/pexp_xfer_fsm.sv
module pexp_xfer_fsm
    import pexp_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               ptr_load,
    output logic [BYTE_W-1:0]  ptr_val,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               rd_stb
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    xfer_st_t          st;
    bit_ph_t           ph;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              ack_go;
    logic              rnw;
    logic [BYTE_W-1:0] rx_byte;
    addr_dec_t         dec;
    logic              rx_state;

    assign rx_byte  = {sh[BYTE_W-2:0], ev.sda};
    assign dec      = decode_addr(rx_byte, strap);
    assign rx_state = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ph       <= PH_BITS;
            cnt      <= '0;
            sh       <= '0;
            ack_go   <= 1'b0;
            rnw      <= 1'b0;
            sda_oe   <= 1'b0;
            ptr_load <= 1'b0;
            ptr_val  <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            rd_stb   <= 1'b0;
        end else begin
            ptr_load <= 1'b0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            if (ev.start) begin
                st     <= ST_ADDR;
                ph     <= PH_BITS;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                ph     <= PH_BITS;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (rx_state) begin
                case (ph)
                    PH_BITS: begin
                        if (ev.scl_rise) begin
                            sh  <= rx_byte;
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                ph     <= PH_ACKWAIT;
                                ack_go <= 1'b1;
                                case (st)
                                    ST_ADDR: begin
                                        rnw <= dec.rnw;
                                        if (!dec.hit) begin
                                            st     <= ST_SKIP;
                                            ph     <= PH_BITS;
                                            ack_go <= 1'b0;
                                        end
                                    end
                                    ST_CMD: begin
                                        ptr_load <= 1'b1;
                                        ptr_val  <= rx_byte;
                                    end
                                    ST_WDATA: begin
                                        wr_stb  <= 1'b1;
                                        wr_data <= rx_byte;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                    PH_ACKWAIT: begin
                        if (ev.scl_fall) begin
                            sda_oe <= ack_go;
                            ph     <= PH_ACK;
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            ph  <= PH_BITS;
                            cnt <= '0;
                            if (st == ST_ADDR && rnw) begin
                                st     <= ST_RDATA;
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                rd_stb <= 1'b1;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= (st == ST_ADDR) ? ST_CMD : ST_WDATA;
                            end
                        end
                    end
                    default: ph <= PH_BITS;
                endcase
            end else if (st == ST_RDATA) begin
                case (ph)
                    PH_BITS: begin
                        if (ev.scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                ph     <= PH_ACK;
                            end else begin
                                sda_oe <= ~sh[BYTE_W-2];
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_rise && ev.sda) begin
                            st <= ST_SKIP;
                            ph <= PH_BITS;
                        end else if (ev.scl_fall) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                            rd_stb <= 1'b1;
                            cnt    <= '0;
                            ph     <= PH_BITS;
                        end
                    end
                    default: ph <= PH_BITS;
                endcase
            end
        end
    end

endmodule

// File: rtl/pexp_i2c_slave.sv
module pexp_i2c_slave
    import pexp_i2c_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_addr,
    output logic [BYTE_W-1:0]  reg_ptr,
    output logic               wr_stb,
    output logic [BYTE_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               rd_stb
);

    bus_ev_t           bus_ev;
    logic              ptr_load;
    logic [BYTE_W-1:0] ptr_val;

    pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (bus_ev)
    );

    pexp_xfer_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .strap    (strap_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb)
    );

    pexp_ptr_reg u_ptr (
        .clk  (clk),
        .rst  (rst),
        .load (ptr_load),
        .val  (ptr_val),
        .ptr  (reg_ptr)
    );

endmodule

// File: rtl/pexp_i2c_slave_chk.sv
module pexp_i2c_slave_chk
    import pexp_i2c_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [BYTE_W-1:0] reg_ptr,
    input bus_ev_t           ev
);

    // R6
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    // R9
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> !sda_oe);

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R6
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    // R8
    ptr_hold_rd_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> $stable(reg_ptr));

    // R5
    ptr_hold_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> $stable(reg_ptr));

endmodule

bind pexp_i2c_slave pexp_i2c_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .reg_ptr (reg_ptr),
    .ev      (bus_ev)
);

// File: tb/pexp_i2c_slave_bench.sv
module pexp_i2c_slave_bench;

    localparam int Q = 10;

    typedef struct {
        bit         is_wr;
        logic [7:0] ptr;
        logic [7:0] data;
    } acc_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b010;
    logic       sda_oe;
    logic [7:0] reg_ptr;
    logic       wr_stb;
    logic [7:0] wr_data;
    logic       rd_stb;
    logic [7:0] rd_data;
    logic       sda_line;
    logic [7:0] regs [4];

    int   checks = 0;
    int   fails = 0;
    int   oe_bad = 0;
    bit   done = 1'b0;
    logic prev_oe = 1'b0;
    acc_t exp_q[$];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = (reg_ptr < 8'd4) ? regs[reg_ptr[1:0]] : 8'h00;

    pexp_i2c_slave u_pexp_i2c_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_oe     (sda_oe),
        .strap_addr (strap),
        .reg_ptr    (reg_ptr),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_stb     (rd_stb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: scoreboard for strobes and bus-timing rule for the pull-down
    always @(negedge clk) begin
        acc_t got;
        if (!rst) begin
            if (sda_oe != prev_oe && scl_m) oe_bad++;
            if (wr_stb || rd_stb) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3/R7 unexpected strobe actual=wr%0d ptr=%0h expected=none",
                             wr_stb, reg_ptr);
                end else begin
                    got = exp_q.pop_front();
                    if (got.is_wr != wr_stb || got.ptr != reg_ptr ||
                        (wr_stb && got.data != wr_data)) begin
                        fails++;
                        $display("FAIL R5/R6 access actual=wr%0d ptr=%0h data=%0h expected=wr%0d ptr=%0h data=%0h",
                                 wr_stb, reg_ptr, wr_data, got.is_wr, got.ptr, got.data);
                    end
                end
                if (wr_stb) regs[reg_ptr[1:0]] <= wr_data;
            end
        end
        prev_oe <= sda_oe;
    end

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl_m = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; waitq();
        scl_m = 1'b1; waitq(); waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic recv_bit(output bit b);
        sda_m = 1'b1; waitq();
        scl_m = 1'b1; waitq();
        b = sda_line; waitq();
        scl_m = 1'b0; waitq();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(s);
        acked = !s;
    endtask

    task automatic read_byte(input bit last, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(s);
            v[i] = s;
        end
        send_bit(last);
    endtask

    task automatic push(input bit w, input logic [7:0] p, input logic [7:0] d);
        acc_t a;
        a.is_wr = w; a.ptr = p; a.data = d;
        exp_q.push_back(a);
    endtask

    function automatic logic [7:0] adr(input logic [2:0] s, input bit rnw);
        return {4'b0100, s, rnw};
    endfunction

    initial begin
        bit         ak;
        logic [7:0] rv;
        regs[0] = 8'h5A; regs[1] = 8'h11; regs[2] = 8'h22; regs[3] = 8'h33;
        repeat (5) @(negedge clk);
        chk(sda_oe == 0 && reg_ptr == 0 && !wr_stb && !rd_stb, "R1 reset state",
            {sda_oe, reg_ptr, wr_stb, rd_stb}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(sda_oe == 0 && reg_ptr == 0, "R1 after reset", {sda_oe, reg_ptr}, 0);

        // Write 0xA5 to register 3
        bus_start();
        send_byte(adr(3'b010, 0), ak); chk(ak, "R2 address ack", ak, 1);
        send_byte(8'h03, ak);          chk(ak, "R4 command ack", ak, 1);
        chk(reg_ptr == 8'h03, "R4 pointer loaded", reg_ptr, 8'h03);
        push(1, 8'h03, 8'hA5);
        send_byte(8'hA5, ak);          chk(ak, "R5 data ack", ak, 1);
        bus_stop();

        // Wrong address: everything ignored
        bus_start();
        send_byte(adr(3'b011, 0), ak); chk(!ak, "R3 mismatch nack", ak, 0);
        send_byte(8'h01, ak);          chk(!ak, "R3 ignored command", ak, 0);
        send_byte(8'h77, ak);          chk(!ak, "R3 ignored data", ak, 0);
        bus_stop();
        chk(reg_ptr == 8'h03, "R3 pointer untouched", reg_ptr, 8'h03);

        // Read-only transfer returns register 3
        push(0, 8'h03, 8'h00);
        bus_start();
        send_byte(adr(3'b010, 1), ak); chk(ak, "R2 read address ack", ak, 1);
        read_byte(1, rv);              chk(rv == 8'hA5, "R8 read last pointer", rv, 8'hA5);
        repeat (4) @(negedge clk);
        chk(sda_oe == 0, "R7 released after nack", sda_oe, 0);
        bus_stop();

        // Two-byte read with master ack
        push(0, 8'h03, 8'h00); push(0, 8'h03, 8'h00);
        bus_start();
        send_byte(adr(3'b010, 1), ak);
        read_byte(0, rv); chk(rv == 8'hA5, "R6 first read byte", rv, 8'hA5);
        read_byte(1, rv); chk(rv == 8'hA5, "R7 second read byte", rv, 8'hA5);
        bus_stop();

        // Command 1 then repeated start into read
        bus_start();
        send_byte(adr(3'b010, 0), ak);
        send_byte(8'h01, ak);
        push(0, 8'h01, 8'h00);
        bus_start();
        send_byte(adr(3'b010, 1), ak); chk(ak, "R9 repeated start ack", ak, 1);
        read_byte(1, rv); chk(rv == 8'h11, "R8 pointer across repeated start", rv, 8'h11);
        bus_stop();
        chk(reg_ptr == 8'h01, "R8 pointer kept", reg_ptr, 8'h01);

        // Multi-byte write to register 2
        bus_start();
        send_byte(adr(3'b010, 0), ak);
        send_byte(8'h02, ak);
        push(1, 8'h02, 8'h3C);
        send_byte(8'h3C, ak); chk(ak, "R5 first data ack", ak, 1);
        push(1, 8'h02, 8'hC3);
        send_byte(8'hC3, ak); chk(ak, "R5 second data ack", ak, 1);
        bus_stop();
        chk(reg_ptr == 8'h02, "R5 pointer unchanged", reg_ptr, 8'h02);

        push(0, 8'h02, 8'h00);
        bus_start();
        send_byte(adr(3'b010, 1), ak);
        read_byte(1, rv); chk(rv == 8'hC3, "R8 read after stop", rv, 8'hC3);
        bus_stop();

        // New strap value
        strap = 3'b101;
        bus_start();
        send_byte(adr(3'b010, 0), ak); chk(!ak, "R3 old strap refused", ak, 0);
        bus_stop();
        bus_start();
        send_byte(adr(3'b101, 0), ak); chk(ak, "R2 new strap ack", ak, 1);
        send_byte(8'h00, ak);
        bus_stop();
        push(0, 8'h00, 8'h00);
        bus_start();
        send_byte(adr(3'b101, 1), ak);
        read_byte(1, rv); chk(rv == 8'h5A, "R8 read register 0", rv, 8'h5A);
        bus_stop();

        // Start in the middle of an address byte
        bus_start();
        send_bit(0); send_bit(1); send_bit(0);
        bus_start();
        send_byte(adr(3'b101, 0), ak); chk(ak, "R9 restart mid byte", ak, 1);
        send_byte(8'h01, ak);
        push(1, 8'h01, 8'h99);
        send_byte(8'h99, ak);
        bus_stop();
        push(0, 8'h01, 8'h00);
        bus_start();
        send_byte(adr(3'b101, 1), ak);
        read_byte(1, rv); chk(rv == 8'h99, "R9 data after restart", rv, 8'h99);
        bus_stop();

        repeat (20) @(negedge clk);
        chk(oe_bad == 0, "R6 pull-down changed with SCL high", oe_bad, 0);
        chk(exp_q.size() == 0, "R7 missing strobes", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule